// File: doc/BRIEF.md
# Microsecond Tick Timer Bank

This block holds a configurable number of independent tick timers (four by default) that share one prescaler. The prescaler divides the bus clock down to a one-microsecond strobe. Every timer owns a control word, a compare value, a counter and a small overflow tally. While a timer is enabled its counter advances by one on each strobe. A strobe that finds the counter equal to the compare value is a match. A match sets the timer's pending flag and raises its interrupt when that is unmasked. It also bumps the overflow tally and, in clear-on-compare mode, returns the counter to zero.

Software reaches every register through one 32-bit word port with no byte enables. The prescaler sits at offset 0x00. Timer i (counting from 0) occupies a 16-byte window at 0x10*(i+1): control at +0x0, compare at +0x4 and counter at +0x8. Reads return data combinationally for the address presented. The interrupt lines are meant for an interrupt controller outside the block.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset the prescaler reads PRE_RESET (124 by default). Every control, compare and counter word reads 0, and all interrupt outputs are low.
- R2: With prescaler value N the strobe fires once every N+1 clocks. Writing the prescaler restarts its phase, so the first strobe comes N+1 clocks after the write edge. An enabled counter advances by exactly one per strobe.
- R3: A counter whose enable bit (control bit 0) is clear holds its value.
- R4: A match occurs on a strobe while the timer is enabled and its counter equals its compare value. A match sets the pending flag, readable at control bit 3, and adds one to the 4-bit overflow tally at control bits 7:4, which wraps modulo 16.
- R5: With clear-on-compare (control bit 1) set, a match loads the counter with 0. Without it, the counter continues to compare+1.
- R6: A software write to a counter takes priority over that cycle's increment. The written value is the counter's value after the write edge.
- R7: Writing control with bit 3 set clears the pending flag and the overflow tally. When a match falls in the same cycle, the match wins: the flag stays set and the tally becomes 1. Written bits 7:4 are ignored.
- R8: Only the offsets listed above are mapped, and only at word-aligned addresses (address bits 1:0 zero). Reads of any other address return 0, and writes to them change nothing.
- R9: The timers are independent. An access to one timer never alters another timer's registers.
- R10: Each interrupt output equals that timer's pending flag ANDed with its interrupt-enable bit (control bit 2). A masked match still records the flag and the tally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for a full 32-bit word |
| addr | input | ADDR_W (8) | Byte address of the accessed register |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Combinational read data for addr |
| irq | output | NUM_TMR (4) | Per-timer interrupt requests |

## Verification
A write takes effect on the clock edge that samples it. Because reads are combinational, the new register value can be read in the next cycle. A counter therefore shows a written value plus any strobes that arrived on later edges. The pending flag, the tally and the interrupt line change on the same edge as the match. The first strobe after a prescaler write lands N+1 edges later. The bench drives inputs on the falling edge and samples shortly after it. It also keeps a cycle-exact reference of the register state, advanced on each rising edge from the inputs it drove, so every read and every interrupt sample is compared with the value due in that exact cycle. The directed literal cases count those edges explicitly.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int DATA_W       = 32;
  localparam int OVF_W        = 4;
  localparam int CTRL_EN      = 0;
  localparam int CTRL_CLR     = 1;
  localparam int CTRL_IE      = 2;
  localparam int CTRL_ACK     = 3;
  localparam int CTRL_OVF_LSB = 4;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_CMP  = 2'd1,
    REG_CNT  = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  // overflow tally after a possible match and a possible acknowledge
  function automatic logic [OVF_W-1:0] ovf_next(input logic [OVF_W-1:0] cur,
                                                input logic hit, input logic ack);
    logic [OVF_W-1:0] base;
    base = ack ? '0 : cur;
    return hit ? base + OVF_W'(1) : base;
  endfunction

  // pending flag: a match wins over an acknowledge
  function automatic logic flag_next(input logic cur, input logic hit, input logic ack);
    return hit | (cur & ~ack);
  endfunction
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int PRE_W     = 16,
  parameter int PRE_RESET = 124
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [PRE_W-1:0] load_val,
  output logic [PRE_W-1:0] div_q,
  output logic             tick
);
  logic [PRE_W-1:0] phase_q;

  assign tick = (phase_q == div_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q   <= PRE_W'(PRE_RESET);
      phase_q <= '0;
    end else if (load) begin
      div_q   <= load_val;
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + PRE_W'(1);
    end
  end
endmodule

// File: rtl/tick_timer_chan.sv
module tick_timer_chan
  import tick_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_ctrl,
  input  logic              wr_cmp,
  input  logic              wr_cnt,
  input  logic [DATA_W-1:0] wdata,
  output logic [CNT_W-1:0]  count_q,
  output logic [CNT_W-1:0]  compare_q,
  output logic [7:0]        ctrl_rd,
  output logic              irq,
  output logic              match,
  output logic              ack,
  output logic              en,
  output logic              clr_mode,
  output logic              flag,
  output logic [OVF_W-1:0]  ovf
);
  logic en_q, clr_q, ie_q, flag_q;
  logic [OVF_W-1:0] ovf_q;

  function automatic logic [CNT_W-1:0] count_next(
      input logic [CNT_W-1:0] cur, input logic sw_wr, input logic [CNT_W-1:0] sw_val,
      input logic step, input logic wrap);
    if (sw_wr)     return sw_val;
    else if (wrap) return '0;
    else if (step) return cur + CNT_W'(1);
    else           return cur;
  endfunction

  assign match    = en_q & tick & (count_q == compare_q);
  assign ack      = wr_ctrl & wdata[CTRL_ACK];
  assign en       = en_q;
  assign clr_mode = clr_q;
  assign flag     = flag_q;
  assign ovf      = ovf_q;
  assign irq      = flag_q & ie_q;
  assign ctrl_rd  = {ovf_q, flag_q, ie_q, clr_q, en_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q      <= 1'b0;
      clr_q     <= 1'b0;
      ie_q      <= 1'b0;
      flag_q    <= 1'b0;
      ovf_q     <= '0;
      count_q   <= '0;
      compare_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata[CTRL_EN];
        clr_q <= wdata[CTRL_CLR];
        ie_q  <= wdata[CTRL_IE];
      end
      if (wr_cmp) compare_q <= wdata[CNT_W-1:0];
      flag_q  <= flag_next(flag_q, match, ack);
      ovf_q   <= ovf_next(ovf_q, match, ack);
      count_q <= count_next(count_q, wr_cnt, wdata[CNT_W-1:0],
                            en_q & tick, match & clr_q);
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_TMR   = 4,
  parameter int CNT_W     = 32,
  parameter int PRE_W     = 16,
  parameter int PRE_RESET = 124,
  parameter int ADDR_W    = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rd_data,
  output logic [NUM_TMR-1:0] irq
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  reg_sel_e          sel;
  logic              aligned;
  logic              pre_hit;
  logic [PRE_W-1:0]  pre_div;
  logic              us_tick;

  logic [NUM_TMR-1:0]            tmr_hit;
  logic [NUM_TMR-1:0]            ctrl_wr_v, cmp_wr_v, cnt_wr_v;
  logic [NUM_TMR-1:0]            match_v, ack_v, en_v, clr_v, flag_v;
  logic [NUM_TMR-1:0][OVF_W-1:0] ovf_v;
  logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v, cmp_v;
  logic [NUM_TMR-1:0][7:0]       ctrl_v;

  assign slot    = addr[ADDR_W-1:4];
  assign sel     = reg_sel_e'(addr[3:2]);
  assign aligned = (addr[1:0] == 2'b00);
  assign pre_hit = aligned && (slot == '0) && (sel == REG_CTRL);

  tick_prescaler #(.PRE_W(PRE_W), .PRE_RESET(PRE_RESET)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_en & pre_hit),
    .load_val (wdata[PRE_W-1:0]),
    .div_q    (pre_div),
    .tick     (us_tick)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    assign tmr_hit[g]   = aligned && (slot == SLOT_W'(g + 1));
    assign ctrl_wr_v[g] = wr_en & tmr_hit[g] & (sel == REG_CTRL);
    assign cmp_wr_v[g]  = wr_en & tmr_hit[g] & (sel == REG_CMP);
    assign cnt_wr_v[g]  = wr_en & tmr_hit[g] & (sel == REG_CNT);

    tick_timer_chan #(.CNT_W(CNT_W)) u_chan (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (us_tick),
      .wr_ctrl   (ctrl_wr_v[g]),
      .wr_cmp    (cmp_wr_v[g]),
      .wr_cnt    (cnt_wr_v[g]),
      .wdata     (wdata),
      .count_q   (cnt_v[g]),
      .compare_q (cmp_v[g]),
      .ctrl_rd   (ctrl_v[g]),
      .irq       (irq[g]),
      .match     (match_v[g]),
      .ack       (ack_v[g]),
      .en        (en_v[g]),
      .clr_mode  (clr_v[g]),
      .flag      (flag_v[g]),
      .ovf       (ovf_v[g])
    );
  end

  always_comb begin
    rd_data = '0;
    if (pre_hit) rd_data = DATA_W'(pre_div);
    for (int i = 0; i < NUM_TMR; i++) begin
      if (tmr_hit[i]) begin
        case (sel)
          REG_CTRL: rd_data = DATA_W'(ctrl_v[i]);
          REG_CMP:  rd_data = DATA_W'(cmp_v[i]);
          REG_CNT:  rd_data = DATA_W'(cnt_v[i]);
          default:  rd_data = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk
  import tick_timer_pkg::*;
#(
  parameter int NUM_TMR = 4,
  parameter int CNT_W   = 32
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          us_tick,
  input logic [DATA_W-1:0]             wdata,
  input logic [NUM_TMR-1:0]            match_v,
  input logic [NUM_TMR-1:0]            ack_v,
  input logic [NUM_TMR-1:0]            cnt_wr_v,
  input logic [NUM_TMR-1:0]            en_v,
  input logic [NUM_TMR-1:0]            clr_v,
  input logic [NUM_TMR-1:0]            flag_v,
  input logic [NUM_TMR-1:0][OVF_W-1:0] ovf_v,
  input logic [NUM_TMR-1:0][CNT_W-1:0] cnt_v
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_chk
    a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (us_tick && en_v[g] && !match_v[g] && !cnt_wr_v[g])
        |=> cnt_v[g] == $past(cnt_v[g]) + CNT_W'(1));

    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!(us_tick && en_v[g]) && !cnt_wr_v[g]) |=> $stable(cnt_v[g]));

    a_r4_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_v[g]) |-> $past(match_v[g]));

    a_r4_ovf_step: assert property (@(posedge clk) disable iff (!rst_n)
      (match_v[g] && !ack_v[g]) |=> ovf_v[g] == $past(ovf_v[g]) + OVF_W'(1));

    a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (match_v[g] && clr_v[g] && !cnt_wr_v[g]) |=> cnt_v[g] == '0);

    a_r6_sw_write: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr_v[g] |=> cnt_v[g] == $past(wdata[CNT_W-1:0]));

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_v[g] && !match_v[g]) |=> (!flag_v[g] && ovf_v[g] == '0));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(.NUM_TMR(NUM_TMR), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .us_tick  (us_tick),
  .wdata    (wdata),
  .match_v  (match_v),
  .ack_v    (ack_v),
  .cnt_wr_v (cnt_wr_v),
  .en_v     (en_v),
  .clr_v    (clr_v),
  .flag_v   (flag_v),
  .ovf_v    (ovf_v),
  .cnt_v    (cnt_v)
);

// File: tb/tick_timer_bank_test.sv
`timescale 1ns/1ps
module tick_timer_bank_test;
  localparam int NT      = 4;
  localparam int PRE_RST = 124;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rd_data;
  logic [NT-1:0] irq;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  tick_timer_bank uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rd_data(rd_data), .irq(irq)
  );

  // reference state built from the requirements
  logic [15:0] m_pre, m_pc;
  logic [31:0] m_cnt [NT];
  logic [31:0] m_cmp [NT];
  logic        m_en [NT], m_clr [NT], m_ie [NT], m_flag [NT];
  logic [3:0]  m_ovf [NT];

  always @(posedge clk) begin : ref_step
    logic tk, hit, ak;
    logic [7:0] base;
    if (!rst_n) begin
      m_pre <= 16'(PRE_RST);
      m_pc  <= '0;
      for (int i = 0; i < NT; i++) begin
        m_cnt[i] <= '0; m_cmp[i] <= '0; m_en[i] <= 0; m_clr[i] <= 0;
        m_ie[i] <= 0; m_flag[i] <= 0; m_ovf[i] <= '0;
      end
    end else begin
      tk = (m_pc == m_pre);
      if (wr_en && addr == 8'h00) begin
        m_pre <= wdata[15:0];
        m_pc  <= '0;
      end else begin
        m_pc <= tk ? 16'd0 : m_pc + 16'd1;
      end
      for (int i = 0; i < NT; i++) begin
        base = 8'((i + 1) * 16);
        hit  = m_en[i] && tk && (m_cnt[i] == m_cmp[i]);
        ak   = wr_en && addr == base && wdata[3];
        if (wr_en && addr == base + 8'h8) m_cnt[i] <= wdata;
        else if (m_en[i] && tk) m_cnt[i] <= (hit && m_clr[i]) ? 32'd0 : m_cnt[i] + 32'd1;
        if (wr_en && addr == base + 8'h4) m_cmp[i] <= wdata;
        if (wr_en && addr == base) begin
          m_en[i] <= wdata[0]; m_clr[i] <= wdata[1]; m_ie[i] <= wdata[2];
        end
        if (hit) begin
          m_flag[i] <= 1'b1;
          m_ovf[i]  <= ak ? 4'd1 : m_ovf[i] + 4'd1;
        end else if (ak) begin
          m_flag[i] <= 1'b0;
          m_ovf[i]  <= 4'd0;
        end
      end
    end
  end

  function automatic logic [31:0] m_read(input logic [7:0] a);
    int s;
    s = int'(a[7:4]);
    if (a[1:0] != 2'b00) return 32'd0;
    if (s == 0) return (a[3:2] == 2'd0) ? {16'd0, m_pre} : 32'd0;
    if (s > NT) return 32'd0;
    case (a[3:2])
      2'd0: return {24'd0, m_ovf[s-1], m_flag[s-1], m_ie[s-1], m_clr[s-1], m_en[s-1]};
      2'd1: return m_cmp[s-1];
      2'd2: return m_cnt[s-1];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [31:0] m_irq();
    logic [31:0] v;
    v = '0;
    for (int i = 0; i < NT; i++) v[i] = m_flag[i] & m_ie[i];
    return v;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_exp(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rd_data, e);
  endtask

  task automatic rd_mdl(input logic [7:0] a, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    chk(tag, rd_data, m_read(a));
  endtask

  // R10 / R4: interrupt lines compared every cycle
  always @(negedge clk) begin
    if (rst_n && mon_on) begin
      #2;
      chk("R10 irq lines", 32'(irq), m_irq());
    end
  end

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(8 * 190000);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd5150));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd_exp(8'h00, 32'd124, "R1 prescaler");
    for (int i = 0; i < NT; i++) begin
      rd_exp(8'((i + 1) * 16),     32'd0, "R1 ctrl");
      rd_exp(8'((i + 1) * 16 + 4), 32'd0, "R1 compare");
      rd_exp(8'((i + 1) * 16 + 8), 32'd0, "R1 counter");
    end
    chk("R1 irq", 32'(irq), 32'd0);
    mon_on = 1'b1;

    // R2: N=4 gives a strobe every 5 clocks; 10 strobes in 50 edges
    wr(8'h18, 32'd0);
    wr(8'h00, 32'd4);
    wr(8'h10, 32'd1);
    repeat (47) @(negedge clk);
    rd_exp(8'h18, 32'd10, "R2 count after 50 clocks");
    // R4/R10: compare 0 matched once, masked interrupt
    rd_exp(8'h10, 32'h19, "R4 flag and tally");
    chk("R10 masked irq", 32'(irq[0]), 32'd0);
    wr(8'h10, 32'h8);
    rd_exp(8'h10, 32'h0, "R7 ack clears");

    // R5: clear-on-compare with a strobe every clock
    wr(8'h00, 32'd0);
    wr(8'h24, 32'd5);
    wr(8'h28, 32'd0);
    wr(8'h20, 32'h7);
    repeat (30) @(negedge clk);
    chk("R4 irq raised", 32'(irq[1]), 32'd1);
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      addr = 8'h28;
      #1;
      chk("R5 counter bounded", 32'(rd_data <= 32'd5), 32'd1);
      chk("R5 counter model", rd_data, m_read(8'h28));
    end
    wr(8'h20, 32'h8);
    rd_mdl(8'h20, "R7 ack vs match");
    wr(8'h20, 32'h8);
    rd_exp(8'h20, 32'h0, "R7 ack after disable");
    chk("R7 irq low", 32'(irq[1]), 32'd0);
    wr(8'h20, 32'hF0);
    rd_exp(8'h20, 32'h0, "R7 tally bits ignored");

    // R6 and R3/R9
    wr(8'h48, 32'd7);
    wr(8'h34, 32'hFFFF_0000);
    wr(8'h30, 32'h1);
    wr(8'h38, 32'h1234);
    rd_exp(8'h38, 32'h1235, "R6 write beats increment");
    repeat (20) @(negedge clk);
    rd_exp(8'h48, 32'd7, "R3 disabled holds");
    rd_exp(8'h44, 32'd0, "R9 neighbour compare untouched");
    wr(8'h30, 32'h0);

    // R8: unmapped and misaligned accesses
    rd_exp(8'h60, 32'd0, "R8 unmapped slot");
    rd_exp(8'h19, 32'd0, "R8 misaligned read");
    rd_exp(8'h04, 32'd0, "R8 prescaler alias");
    wr(8'h4B, 32'd99);
    rd_exp(8'h48, 32'd7, "R8 misaligned write");
    wr(8'h4C, 32'd5);
    rd_exp(8'h4C, 32'd0, "R8 spare offset");
    wr(8'h64, 32'd3);
    rd_mdl(8'h00, "R8 unmapped write");

    // constrained random phase
    for (int it = 0; it < 2500; it++) begin
      int op, t;
      logic [7:0] a;
      op = int'($urandom % 6);
      t  = int'($urandom % NT);
      a  = 8'((t + 1) * 16);
      case (op)
        0: wr(8'h00, $urandom % 4);
        1: wr(a, $urandom % 16);
        2: wr(a + 8'h4, $urandom % 24);
        3: wr(a + 8'h8, $urandom % 24);
        4: rd_mdl(8'($urandom), "R8 random read");
        default: rd_mdl(a + 8'($urandom % 3) * 8'h4, "R9 random timer read");
      endcase
      repeat ($urandom % 6) @(negedge clk);
    end

    mon_on = 1'b0;
    summary();
  end
endmodule